// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a clocked, synthesizable stand-in for a byte-wide, UV-erasable or one-time-programmable memory. It has active-low chip enable, output enable and program strobe, plus two single-bit flags that stand in for analog levels. One flag marks a raised program supply. The other marks an identification voltage on an address line. From these controls the block picks one of seven modes: read, output disable, program, verify, program inhibit, standby or signature. It drives a byte bus whose enable bit shows when the bus is actively driven. While the enable is low the bus counts as high impedance.

The array begins erased, with every bit set to 1, and the reset returns it to that state. A program pulse can only clear bits: the new word is the old word ANDed with the input byte. Analog access times become clock-cycle counts. The delay counted from output enable is shorter than the delay counted from an address change or from chip enable. A program pulse shorter than a minimum number of cycles is refused, and a status flag reports the refusal.

Top module: `otp_byte_mem`

## Requirements
- R1: While reset is held, and after it is released, every location reads 0xFF, `q_en` is 0 and `pulse_rej` is 0. Asserting reset again erases all locations back to 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `id_hv`=0, once the access delay has elapsed the bus drives the byte at `addr`. Whenever `q_en` is 0, `q_out` reads 0.
- R3: With `ce_n`=1 (standby, or program inhibit when `vpp_hi`=1), the bus is off whatever `oe_n` is. Program strobes given in this state change no location.
- R4: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0 (output disable), the bus is off from the next clock edge on.
- R5: In program mode (`ce_n`=0, `oe_n`=1, `vpp_hi`=1), a pulse is accepted when `pgm_n` stays low for at least MIN_PULSE sampled edges and the edge that samples it high again also samples program mode. On that release edge, location `addr` becomes its old value AND `d_in`.
- R6: Programming never turns a 0 bit into a 1. Programming 0xFF over a location leaves its value unchanged.
- R7: Verify mode (`ce_n`=0, `oe_n`=0, `vpp_hi`=1, `pgm_n`=1) drives the addressed byte. With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=0, the bus stays off.
- R8: With `id_hv`=1, `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `vpp_hi`=0, the bus returns 0x20 when `addr` bit 0 is 0 and 0x61 when it is 1. With `pgm_n`=0 in that state, the bus stays off.
- R9: The access age is 0 at any edge that samples `ce_n`=1 or an address different from the one sampled at the previous edge. Otherwise it grows by one per edge. The bus can drive only at edges where this age has reached ACC_CYC, so an address change turns the bus off at the next edge.
- R10: The output age is 0 at edges that sample `oe_n`=1 and otherwise grows by one per edge. Driving also needs this age to reach OE_CYC (OE_CYC ≤ ACC_CYC). With the address settled and `ce_n` low, data appears OE_CYC edges after `oe_n` falls.
- R11: A pulse released in program mode after fewer than MIN_PULSE low edges writes nothing and sets `pulse_rej` to 1. An accepted pulse clears `pulse_rej` to 0. Between releases the flag holds its value.
- R12: If the mode leaves program mode before the release edge, the pulse is abandoned, for example when `ce_n` or `oe_n` changes in the same edge that `pgm_n` rises. An abandoned pulse writes nothing and leaves `pulse_rej` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset and erase |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Program supply at programming level |
| id_hv | input | 1 | Identification voltage present on the address line |
| addr | input | AW | Byte address |
| d_in | input | DW | Byte to program |
| q_out | output | DW | Bus value, 0 while not driven |
| q_en | output | 1 | Bus driven (0 means high impedance) |
| pulse_rej | output | 1 | Last released program pulse was too short |

## Verification
Two things can fall on the same clock edge: the release of a program pulse, and a control change that moves the block out of program mode. The bench provokes this by raising `pgm_n` together with `ce_n`, and separately together with `oe_n` falling. It then judges the outcome at the bus: the location must still read 0xFF, and `pulse_rej` must keep its earlier value. A second overlap is an output-enable fall that lands while the address is already settled. Here only the shorter output delay may govern, and a behavioural reference model compares every bus sample on every cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_INHIBIT = 3'd1,
    MD_OUTDIS  = 3'd2,
    MD_PROG    = 3'd3,
    MD_READ    = 3'd4,
    MD_VERIFY  = 3'd5,
    MD_SIGN    = 3'd6,
    MD_INVALID = 3'd7
  } otp_mode_e;

  localparam logic [7:0] SIG_MAKER = 8'h20;
  localparam logic [7:0] SIG_PART  = 8'h61;

  function automatic logic mode_drives(input otp_mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_SIGN);
  endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      pgm_n,
  input  logic      vpp_hi,
  input  logic      id_hv,
  output otp_mode_e mode
);

  always_comb begin
    mode = MD_INVALID;
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    end else if (oe_n) begin
      mode = vpp_hi ? MD_PROG : MD_OUTDIS;
    end else if (vpp_hi) begin
      mode = pgm_n ? MD_VERIFY : MD_INVALID;
    end else if (id_hv) begin
      mode = pgm_n ? MD_SIGN : MD_INVALID;
    end else begin
      mode = MD_READ;
    end
  end

endmodule

// File: rtl/otp_access_timer.sv
module otp_access_timer #(
  parameter int AW      = 8,
  parameter int ACC_CYC = 4,
  parameter int OE_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic          acc_ok,
  output logic          oe_ok
);

  localparam int AGW = $clog2(ACC_CYC + 2);
  localparam int OGW = $clog2(OE_CYC + 2);
  localparam logic [AGW-1:0] ACC_LIM = AGW'(ACC_CYC);
  localparam logic [OGW-1:0] OE_LIM  = OGW'(OE_CYC);

  logic [AW-1:0]  addr_q;
  logic [AGW-1:0] acc_q, acc_d;
  logic [OGW-1:0] oe_q, oe_d;

  always_comb begin
    acc_d = acc_q;
    if (ce_n || (addr != addr_q)) begin
      acc_d = '0;
    end else if (acc_q < ACC_LIM) begin
      acc_d = acc_q + 1'b1;
    end
  end

  always_comb begin
    oe_d = oe_q;
    if (oe_n) begin
      oe_d = '0;
    end else if (oe_q < OE_LIM) begin
      oe_d = oe_q + 1'b1;
    end
  end

  assign acc_ok = (acc_d >= ACC_LIM);
  assign oe_ok  = (oe_d >= OE_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      acc_q  <= '0;
      oe_q   <= '0;
    end else begin
      addr_q <= addr;
      acc_q  <= acc_d;
      oe_q   <= oe_d;
    end
  end

  generate
    if (ACC_CYC >= 2) begin : g_acc_chk
      // R9: a full access age needs chip enable held low on the previous edge
      a_r9_age_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |-> ($past(!ce_n) && !ce_n));
    end
    if (OE_CYC >= 2) begin : g_oe_chk
      // R10: output age needs output enable low on the previous edge
      a_r10_oe_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ok |-> $past(!oe_n));
    end
  endgenerate

endmodule

// File: rtl/otp_pulse_ctrl.sv
module otp_pulse_ctrl #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_mode,
  input  logic pgm_n,
  output logic wr_en,
  output logic rej
);

  localparam int WW = $clog2(MIN_PULSE + 2);
  localparam logic [WW-1:0] W_LIM = WW'(MIN_PULSE);

  logic [WW-1:0] wid_q, wid_d;
  logic          rej_q, rej_d;
  logic          release_evt;

  assign release_evt = prog_mode && pgm_n && (wid_q != '0);

  always_comb begin
    wid_d = '0;
    if (prog_mode && !pgm_n) begin
      wid_d = (wid_q < W_LIM) ? wid_q + 1'b1 : wid_q;
    end
  end

  always_comb begin
    rej_d = rej_q;
    if (release_evt) begin
      rej_d = (wid_q < W_LIM);
    end
  end

  assign wr_en = release_evt && (wid_q >= W_LIM);
  assign rej   = rej_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q <= '0;
      rej_q <= 1'b0;
    end else begin
      wid_q <= wid_d;
      rej_q <= rej_d;
    end
  end

  // R12: a write only follows an edge that saw the strobe low in program mode
  a_r12_write_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(prog_mode && !pgm_n));

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] wr_old, wr_new;

  assign wr_old = mem_q[waddr];
  assign wr_new = wr_old & wdata;
  assign rdata  = mem_q[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '1;
      end
    end else if (we) begin
      mem_q[waddr] <= wr_new;
    end
  end

  // R6: after a write no bit of the word has gone from 0 to 1
  a_r6_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((mem_q[$past(waddr)] & ~$past(wr_old)) == '0));

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int ACC_CYC   = 4,
  parameter int OE_CYC    = 2,
  parameter int MIN_PULSE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic          vpp_hi,
  input  logic          id_hv,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] q_out,
  output logic          q_en,
  output logic          pulse_rej
);

  localparam logic [DW-1:0] CODE_MAKER = DW'(SIG_MAKER);
  localparam logic [DW-1:0] CODE_PART  = DW'(SIG_PART);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  otp_mode_e     mode;
  logic          acc_ok, oe_ok;
  logic          wr_en;
  logic [DW-1:0] arr_byte, sel_byte;
  logic          drive_d;
  logic [DW-1:0] out_d;
  logic          q_en_q;
  logic [DW-1:0] q_out_q;

  otp_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_hi (vpp_hi),
    .id_hv  (id_hv),
    .mode   (mode)
  );

  otp_access_timer #(
    .AW      (AW),
    .ACC_CYC (ACC_CYC),
    .OE_CYC  (OE_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_i),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .addr   (addr),
    .acc_ok (acc_ok),
    .oe_ok  (oe_ok)
  );

  otp_pulse_ctrl #(
    .MIN_PULSE (MIN_PULSE)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_i),
    .prog_mode (mode == MD_PROG),
    .pgm_n     (pgm_n),
    .wr_en     (wr_en),
    .rej       (pulse_rej)
  );

  otp_cell_array #(
    .AW (AW),
    .DW (DW)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_i),
    .we    (wr_en),
    .waddr (addr),
    .wdata (d_in),
    .raddr (addr),
    .rdata (arr_byte)
  );

  always_comb begin
    sel_byte = arr_byte;
    if (mode == MD_SIGN) begin
      sel_byte = addr[0] ? CODE_PART : CODE_MAKER;
    end
  end

  assign drive_d = mode_drives(mode) && acc_ok && oe_ok;
  assign out_d   = drive_d ? sel_byte : '0;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      q_en_q  <= 1'b0;
      q_out_q <= '0;
    end else begin
      q_en_q  <= drive_d;
      q_out_q <= out_d;
    end
  end

  assign q_en  = q_en_q;
  assign q_out = q_out_q;

  // R3: chip enable high on the last edge means the bus is off now
  a_r3_off_in_standby: assert property (@(posedge clk) disable iff (!rst_i)
    $past(ce_n) |-> !q_en);

  // R4: output disable on the last edge means the bus is off now
  a_r4_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_i)
    $past(!ce_n && oe_n) |-> !q_en);

  // R8: signature mode only ever shows one of the two codes
  a_r8_sig_codes: assert property (@(posedge clk) disable iff (!rst_i)
    (q_en && $past(id_hv && !vpp_hi)) |-> (q_out == CODE_MAKER || q_out == CODE_PART));

  // R11: the refusal flag only rises after a strobe release in program mode
  a_r11_reject_at_release: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(pulse_rej) |-> $past(pgm_n && !ce_n && oe_n && vpp_hi));

  // R2: a bus that is not driven carries zero
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_i)
    !q_en |-> (q_out == '0));

endmodule

// File: tb/otp_byte_mem_bench.sv
module otp_byte_mem_bench;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int ACC = 4;
  localparam int OEC = 2;
  localparam int MINP = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;
  logic          q_en;
  logic          pulse_rej;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  otp_byte_mem #(
    .AW(AW), .DW(DW), .ACC_CYC(ACC), .OE_CYC(OEC), .MIN_PULSE(MINP)
  ) u_otp_byte_mem (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .id_hv(id_hv), .addr(addr), .d_in(d_in),
    .q_out(q_out), .q_en(q_en), .pulse_rej(pulse_rej)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_mem [DEPTH];
  int  m_acc, m_oe, m_wid, m_prev_addr, m_live;
  bit  m_rej, m_en;
  int  m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_acc = 0; m_oe = 0; m_wid = 0; m_prev_addr = 0; m_live = 0;
      m_rej = 0; m_en = 0; m_out = 0;
    end else if (m_live < 2) begin
      m_live++;
    end else begin
      bit prog, drv, sig;
      int val;
      prog = !ce_n && oe_n && vpp_hi;
      sig  = !ce_n && !oe_n && !vpp_hi && id_hv && pgm_n;
      drv  = !ce_n && !oe_n && (vpp_hi ? pgm_n : (!id_hv || pgm_n));
      if (ce_n || int'(addr) != m_prev_addr) m_acc = 0;
      else if (m_acc < ACC) m_acc++;
      m_prev_addr = int'(addr);
      if (oe_n) m_oe = 0;
      else if (m_oe < OEC) m_oe++;
      val = sig ? (addr[0] ? 8'h61 : 8'h20) : m_mem[addr];
      m_en  = drv && m_acc >= ACC && m_oe >= OEC;
      m_out = m_en ? val : 0;
      if (prog && pgm_n && m_wid > 0) begin
        if (m_wid >= MINP) begin
          m_mem[addr] = m_mem[addr] & int'(d_in);
          m_rej = 0;
        end else begin
          m_rej = 1;
        end
      end
      m_wid = (prog && !pgm_n) ? ((m_wid < MINP) ? m_wid + 1 : m_wid) : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_live >= 2 && !done) begin
      check("R9 model bus enable", int'(q_en), int'(m_en));
      check("R2 model bus value", int'(q_out), m_out);
      check("R11 model reject flag", int'(pulse_rej), int'(m_rej));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hi = 0; id_hv = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 0;
    tick(3);
    rst_n = 1;
    tick(4);
  endtask

  // program one byte with a pulse of w low edges, leaving read-ready controls
  task automatic prog(input int a, input int d, input int w);
    ce_n = 0; oe_n = 1; vpp_hi = 1; id_hv = 0; addr = AW'(a); d_in = DW'(d);
    tick(1);
    pgm_n = 0;
    tick(w);
    pgm_n = 1;
    tick(1);
  endtask

  task automatic read_at(input int a, output int en, output int v);
    ce_n = 0; oe_n = 0; vpp_hi = 0; id_hv = 0; pgm_n = 1; addr = AW'(a);
    tick(ACC + 2);
    en = int'(q_en); v = int'(q_out);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int en, v;
    idle();
    tick(3);
    check("R1 bus off in reset", int'(q_en), 0);
    check("R1 flag clear in reset", int'(pulse_rej), 0);
    rst_n = 1;
    tick(4);
    check("R1 bus off after reset", int'(q_en), 0);

    // access latency from address change (R9) and erased value (R1)
    ce_n = 0; oe_n = 0; addr = 8'd5;
    tick(ACC);
    check("R9 not yet driven", int'(q_en), 0);
    tick(1);
    check("R9 driven after access age", int'(q_en), 1);
    check("R1 erased byte", int'(q_out), 8'hFF);

    // program and read back through the fast output path
    prog(5, 8'hA5, MINP);
    check("R5 accepted pulse flag", int'(pulse_rej), 0);
    oe_n = 0; vpp_hi = 0;
    tick(OEC - 1);
    check("R10 before output delay", int'(q_en), 0);
    tick(1);
    check("R10 output path on", int'(q_en), 1);
    check("R5 programmed value", int'(q_out), 8'hA5);

    // AND behaviour and one-way bits
    prog(5, 8'h5A, MINP + 2);
    prog(5, 8'hFF, MINP);
    ce_n = 0; oe_n = 0; vpp_hi = 1; pgm_n = 1;
    tick(OEC + 1);
    check("R7 verify drives", int'(q_en), 1);
    check("R6 bits stay cleared", int'(q_out), 8'h00);
    pgm_n = 0;
    tick(1);
    check("R7 strobe low in verify is off", int'(q_en), 0);
    pgm_n = 1;

    // short pulse refused
    prog(6, 8'h00, MINP - 1);
    check("R11 short pulse flagged", int'(pulse_rej), 1);
    read_at(6, en, v);
    check("R11 short pulse no write", v, 8'hFF);
    prog(6, 8'h0F, MINP);
    check("R11 flag cleared by accepted pulse", int'(pulse_rej), 0);
    read_at(6, en, v);
    check("R5 second location", v, 8'h0F);

    // release together with chip enable rising
    ce_n = 0; oe_n = 1; vpp_hi = 1; addr = 8'd7; d_in = 8'h00;
    tick(1);
    pgm_n = 0;
    tick(MINP);
    pgm_n = 1; ce_n = 1;
    tick(1);
    check("R12 abandoned flag unchanged", int'(pulse_rej), 0);
    // release together with output enable falling
    ce_n = 0;
    tick(1);
    pgm_n = 0;
    tick(MINP + 1);
    pgm_n = 1; oe_n = 0;
    tick(1);
    vpp_hi = 0;
    read_at(7, en, v);
    check("R12 abandoned pulse no write", v, 8'hFF);

    // standby and program inhibit
    ce_n = 1; oe_n = 0; vpp_hi = 0; addr = 8'd7;
    tick(2);
    check("R3 standby bus off", int'(q_en), 0);
    vpp_hi = 1; oe_n = 1; addr = 8'd8; d_in = 8'h00;
    tick(1);
    pgm_n = 0;
    tick(MINP + 1);
    pgm_n = 1;
    tick(2);
    check("R3 inhibit bus off", int'(q_en), 0);
    read_at(8, en, v);
    check("R3 inhibit no write", v, 8'hFF);

    // output disable after driving
    check("R2 read drives", en, 1);
    oe_n = 1;
    tick(1);
    check("R4 output disable", int'(q_en), 0);

    // address change turns bus off at once
    oe_n = 0;
    tick(OEC + 1);
    check("R2 read again", int'(q_en), 1);
    addr = 8'd5;
    tick(1);
    check("R9 address change turns off", int'(q_en), 0);
    tick(ACC);
    check("R2 new address value", int'(q_out), 8'h00);

    // signature codes
    id_hv = 1; addr = 8'd0;
    tick(ACC + 2);
    check("R8 maker code", int'(q_out), 8'h20);
    addr = 8'd1;
    tick(ACC + 2);
    check("R8 part code", int'(q_out), 8'h61);
    pgm_n = 0;
    tick(1);
    check("R8 strobe low gives no code", int'(q_en), 0);
    idle();
    tick(2);

    // erase by reset
    do_reset();
    read_at(5, en, v);
    check("R1 erase restores ones", v, 8'hFF);
    idle();
    tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule